// File: doc/BRIEF.md
# Byte-Wide Configuration Register Responder

This block is the target side of an 8-bit reconfiguration port. A master presents a 21-bit address with a read or write strobe. The responder keeps a small byte array for each function. Each byte powers up to, and returns to on every reset, a default value computed from its function number and offset. Writes land in the addressed byte. Reads come back a fixed number of cycles later, marked by a one-cycle valid strobe.

The address is decoded into three parts. The top bit selects configuration space. One or two bits above the byte offset carry the function number, and any remaining upper bits are reserved and must be zero. An access that fails the decode leaves all state unchanged, and a read of such an address still completes and returns zero. Only one request is handled at a time, and waitrequest holds the master off while the responder is busy.

The control path is a five-state machine:
- `ST_IDLE` accepts requests.
- `ST_RD_A` and `ST_RD_B` are the two read latency stages.
- `ST_RD_RSP` is the cycle in which read data is presented.
- `ST_WR_GAP` is the single busy cycle after a write.

Its transitions are:
- `IDLE->RD_A` on an accepted read, taken even when a write is asserted with it.
- `IDLE->WR_GAP` on an accepted write with no read.
- `RD_A->RD_B` and `RD_B->RD_RSP` unconditionally.
- `RD_RSP->IDLE` and `WR_GAP->IDLE` unconditionally.

Top module: `cfg_reconf_responder`

## Requirements
- R1: While rst_n is low and after it rises, waitrequest and readdatavalid are 0 and readdata is 0x00. Every stored byte of function f at offset o reads as (o mod 256) XOR (0x11 * (f+1)), truncated to 8 bits.
- R2: Address bit 20 selects configuration space, bits [13:12] carry the function number (default four functions), and bits [11:0] carry the byte offset. A write to a valid address is returned by a later read of that address.
- R3: A read is accepted on a rising edge where read is 1 and waitrequest is 0. Counting that edge as 0, readdatavalid is 1 only in the cycle between edges 2 and 3, and it carries the data. In all other cycles readdata is 0x00.
- R4: waitrequest is 1 from the edge that accepts a read up to and including the readdatavalid cycle, and 0 in the cycle after it. A request held during that time is accepted only once waitrequest has fallen.
- R5: After an accepted write, waitrequest is 1 for exactly one cycle.
- R6: An access with address bit 20 clear changes no byte, and a read of it returns 0x00 with readdatavalid.
- R7: An access with any of bits [19:14] set changes no byte and reads as 0x00. In a variant with fewer than four functions, the same applies to a function number that is out of range.
- R8: An offset of 256 (the STORE_BYTES default) or more changes no byte, does not alias onto a lower offset, and reads as 0x00.
- R9: When read and write are both asserted in the idle state, only the read is performed and the write is discarded.
- R10: A reset discards every earlier write, and each byte returns to its R1 default.
- R11: A write to one function leaves the same offset in the other functions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reconfiguration clock, 100 to 125 MHz |
| rst_n | input | 1 | Active-low asynchronous reset that restores the defaults |
| address | input | 21 | Space select, reserved bits, function number and byte offset |
| read | input | 1 | Read request |
| write | input | 1 | Write request |
| writedata | input | 8 | Byte to be written |
| readdata | output | 8 | Returned byte, 0x00 outside the valid cycle |
| readdatavalid | output | 1 | One-cycle strobe marking readdata |
| waitrequest | output | 1 | Responder busy; the request is not accepted |

## Verification
Read-back uses 0x00, 0xFF, 0xA5 and 0x5A at the lowest and highest stored offsets of several functions. These patterns separate a stuck data bit from a swapped byte, and comparing the same offset across functions exposes function-select mistakes. Addresses that should be ignored are built by changing one field at a time: space bit cleared, a single reserved bit set, offset just past the limit, and an offset whose low byte matches a stored one. Each is followed by a read of the byte it could have reached, which tells a decode hole apart from aliasing. A read issued together with a write, and a write held behind an outstanding read, check both the busy window and the request priority. A reset after writes checks that the defaults are restored.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_RD_RSP,
        ST_WR_GAP
    } cfgr_state_e;

    // Reset value of one stored byte: offset XOR (0x11 * (function + 1)).
    function automatic logic [7:0] dflt_byte(input int unsigned func_id,
                                             input int unsigned offset);
        logic [7:0] salt;
        salt = 8'(8'h11 * (func_id + 1));
        return 8'(offset) ^ salt;
    endfunction

endpackage

// File: rtl/cfgr_addr_decode.sv
module cfgr_addr_decode #(
    parameter int unsigned ADDR_W      = 21,
    parameter int unsigned NUM_FUNC    = 4,
    parameter int unsigned STORE_BYTES = 256,
    localparam int unsigned FUNC_W     = (NUM_FUNC > 2) ? 2 : 1,
    localparam int unsigned OFF_W      = $clog2(STORE_BYTES),
    localparam int unsigned RSV_LO     = 12 + FUNC_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [1:0]        func,
    output logic [OFF_W-1:0]  off_idx
);

    logic              space_sel;
    logic              rsv_clear;
    logic              func_ok;
    logic              off_ok;
    logic [FUNC_W-1:0] func_raw;
    logic [11:0]       off_full;

    always_comb begin
        space_sel = addr[ADDR_W-1];
        rsv_clear = (addr[ADDR_W-2:RSV_LO] == '0);
        func_raw  = addr[12 +: FUNC_W];
        off_full  = addr[11:0];
        func_ok   = (32'(func_raw) < NUM_FUNC);
        off_ok    = (32'(off_full) < STORE_BYTES);
        hit       = space_sel && rsv_clear && func_ok && off_ok;
        func      = 2'(func_raw);
        off_idx   = off_full[OFF_W-1:0];
    end

endmodule

// File: rtl/cfgr_func_bank.sv
module cfgr_func_bank #(
    parameter int unsigned FUNC_ID     = 0,
    parameter int unsigned STORE_BYTES = 256,
    localparam int unsigned OFF_W      = $clog2(STORE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [OFF_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    import cfgr_pkg::*;

    logic [7:0] mem [STORE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STORE_BYTES); i++) begin
                mem[i] <= dflt_byte(FUNC_ID, i);
            end
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/cfgr_ctrl_fsm.sv
module cfgr_ctrl_fsm
    import cfgr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_req,
    input  logic        wr_req,
    output logic        rd_take,
    output logic        wr_take,
    output logic        busy,
    output logic        load_rsp,
    output cfgr_state_e state
);

    cfgr_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_req)      state_nx = ST_RD_A;
                else if (wr_req) state_nx = ST_WR_GAP;
            end
            ST_RD_A:   state_nx = ST_RD_B;
            ST_RD_B:   state_nx = ST_RD_RSP;
            ST_RD_RSP: state_nx = ST_IDLE;
            ST_WR_GAP: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_take  = 1'b0;
        wr_take  = 1'b0;
        busy     = 1'b1;
        load_rsp = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy    = 1'b0;
                rd_take = rd_req;
                wr_take = wr_req && !rd_req;
            end
            ST_RD_B:   load_rsp = 1'b1;
            ST_RD_A, ST_RD_RSP, ST_WR_GAP: ;
            default:   busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfg_reconf_responder.sv
module cfg_reconf_responder #(
    parameter int unsigned ADDR_W      = 21,
    parameter int unsigned NUM_FUNC    = 4,
    parameter int unsigned STORE_BYTES = 256,
    localparam int unsigned OFF_W      = $clog2(STORE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] address,
    input  logic              read,
    input  logic              write,
    input  logic [7:0]        writedata,
    output logic [7:0]        readdata,
    output logic              readdatavalid,
    output logic              waitrequest
);
    import cfgr_pkg::*;

    logic             hit;
    logic [1:0]       func;
    logic [OFF_W-1:0] off_idx;
    logic             rd_take;
    logic             wr_take;
    logic             busy;
    logic             load_rsp;
    cfgr_state_e      state;
    logic [7:0]       bank_rdata [NUM_FUNC];
    logic [7:0]       sel_byte;
    logic [7:0]       rd_hold;
    logic [7:0]       rsp_q;

    cfgr_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_FUNC(NUM_FUNC), .STORE_BYTES(STORE_BYTES)
    ) u_dec (
        .addr(address), .hit(hit), .func(func), .off_idx(off_idx)
    );

    cfgr_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_req(read), .wr_req(write),
        .rd_take(rd_take), .wr_take(wr_take), .busy(busy),
        .load_rsp(load_rsp), .state(state)
    );

    for (genvar f = 0; f < int'(NUM_FUNC); f++) begin : g_bank
        logic we_f;
        assign we_f = wr_take && hit && (func == 2'(f));
        cfgr_func_bank #(.FUNC_ID(f), .STORE_BYTES(STORE_BYTES)) u_bank (
            .clk(clk), .rst_n(rst_n), .we(we_f), .idx(off_idx),
            .wdata(writedata), .rdata(bank_rdata[f])
        );
    end

    always_comb begin
        sel_byte = 8'h00;
        for (int f = 0; f < int'(NUM_FUNC); f++) begin
            if (hit && (func == 2'(f))) sel_byte = bank_rdata[f];
        end
    end

    // Latency pipeline: captured at acceptance, presented in ST_RD_RSP only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_hold <= 8'h00;
            rsp_q   <= 8'h00;
        end else begin
            if (rd_take) rd_hold <= sel_byte;
            rsp_q <= load_rsp ? rd_hold : 8'h00;
        end
    end

    assign readdata      = rsp_q;
    assign readdatavalid = (state == ST_RD_RSP);
    assign waitrequest   = busy;

endmodule

// File: rtl/cfgr_chk.sv
module cfgr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       space_bit,
    input logic       read,
    input logic       write,
    input logic [7:0] readdata,
    input logic       readdatavalid,
    input logic       waitrequest
);

    // R3
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (read && !waitrequest) |=> ##2 readdatavalid);

    // R3
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        readdatavalid |=> !readdatavalid);

    // R4
    rdv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        readdatavalid |-> waitrequest);

    // R4
    rdv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        readdatavalid |=> !waitrequest);

    // R5
    wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (write && !read && !waitrequest) |=> (waitrequest ##1 !waitrequest));

    // R6
    space_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (read && !waitrequest && !space_bit) |=> ##2 (readdata == 8'h00));

endmodule

bind cfg_reconf_responder cfgr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .space_bit(address[20]),
    .read(read), .write(write), .readdata(readdata),
    .readdatavalid(readdatavalid), .waitrequest(waitrequest)
);

// File: tb/cfg_reconf_responder_tb.sv
module cfg_reconf_responder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] address = '0;
    logic        read = 1'b0;
    logic        write = 1'b0;
    logic [7:0]  writedata = '0;
    logic [7:0]  readdata;
    logic        readdatavalid;
    logic        waitrequest;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct { logic [7:0] exp; string tag; } exp_t;
    exp_t sbq[$];
    logic [7:0] mdl [4][256];

    always #4 clk = ~clk;

    cfg_reconf_responder u_dut (
        .clk(clk), .rst_n(rst_n), .address(address), .read(read),
        .write(write), .writedata(writedata), .readdata(readdata),
        .readdatavalid(readdatavalid), .waitrequest(waitrequest)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [20:0] mk(input int f, input int off);
        return {1'b1, 6'b0, 2'(f), 12'(off)};
    endfunction

    function automatic bit dec_hit(input logic [20:0] a);
        return a[20] && (a[19:14] == 6'b0) && (a[11:0] < 12'd256);
    endfunction

    function automatic logic [7:0] mdl_rd(input logic [20:0] a);
        return dec_hit(a) ? mdl[a[13:12]][a[7:0]] : 8'h00;
    endfunction

    task automatic mdl_init();
        for (int f = 0; f < 4; f++)
            for (int o = 0; o < 256; o++)
                mdl[f][o] = 8'(o) ^ 8'(8'h11 * (f + 1));
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && readdatavalid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R3", "unexpected readdatavalid", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(readdata == e.exp, e.tag, "readdata", readdata, e.exp);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; read = 1'b0; write = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!waitrequest && !readdatavalid && readdata == 8'h00, "R1",
            "outputs in reset", {waitrequest, readdatavalid, readdata}, 0);
        mdl_init();
        rst_n = 1'b1;
        @(negedge clk);
        chk(!waitrequest && !readdatavalid && readdata == 8'h00, "R1",
            "outputs after reset", {waitrequest, readdatavalid, readdata}, 0);
    endtask

    task automatic bus_read(input logic [20:0] a, input string tag);
        exp_t e;
        address = a; read = 1'b1;
        while (waitrequest) @(negedge clk);
        e.exp = mdl_rd(a); e.tag = tag;
        sbq.push_back(e);
        @(negedge clk); read = 1'b0;
        chk(waitrequest && !readdatavalid, "R4", "cycle 1 busy", {waitrequest, readdatavalid}, 2);
        @(negedge clk);
        chk(waitrequest && !readdatavalid, "R3", "cycle 2 no data", {waitrequest, readdatavalid}, 2);
        @(negedge clk);
        chk(waitrequest && readdatavalid, "R3", "cycle 3 valid", {waitrequest, readdatavalid}, 3);
        @(negedge clk);
        chk(!waitrequest && !readdatavalid && readdata == 8'h00, "R4", "released",
            {waitrequest, readdatavalid, readdata}, 0);
    endtask

    task automatic bus_write(input logic [20:0] a, input logic [7:0] d);
        address = a; writedata = d; write = 1'b1;
        while (waitrequest) @(negedge clk);
        if (dec_hit(a)) mdl[a[13:12]][a[7:0]] = d;
        @(negedge clk); write = 1'b0;
        chk(waitrequest == 1'b1, "R5", "gap cycle busy", waitrequest, 1);
        @(negedge clk);
        chk(waitrequest == 1'b0, "R5", "gap cycle over", waitrequest, 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R3", "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
        do_reset();

        // R1 defaults in every function at both ends of storage
        for (int f = 0; f < 4; f++) begin
            bus_read(mk(f, 0), "R1");
            bus_read(mk(f, 255), "R1");
        end

        // R2 write/read patterns, R11 independence
        for (int i = 0; i < 4; i++) begin
            bus_write(mk(i, 255 - i), pats[i]);
            bus_write(mk(3 - i, i), pats[3 - i]);
        end
        for (int i = 0; i < 4; i++) begin
            bus_read(mk(i, 255 - i), "R2");
            bus_read(mk(3 - i, i), "R2");
        end
        bus_write(mk(1, 16), 8'hC3);
        bus_read(mk(1, 16), "R2");
        bus_read(mk(0, 16), "R11");
        bus_read(mk(2, 16), "R11");

        // R6 space bit cleared
        bus_write(mk(0, 32) & ~21'h100000, 8'h77);
        bus_read(mk(0, 32), "R6");
        bus_read(mk(0, 32) & ~21'h100000, "R6");

        // R7 reserved bits
        bus_write(mk(2, 40) | 21'h004000, 8'h66);
        bus_write(mk(2, 40) | 21'h080000, 8'h99);
        bus_read(mk(2, 40), "R7");
        bus_read(mk(2, 40) | 21'h004000, "R7");

        // R8 offset beyond storage, no aliasing
        bus_write(mk(3, 256 + 5), 8'h12);
        bus_write(mk(3, 12'hFFF), 8'h34);
        bus_read(mk(3, 5), "R8");
        bus_read(mk(3, 255), "R8");
        bus_read(mk(3, 256 + 5), "R8");

        // R9 read and write together: read wins, write dropped
        begin
            exp_t e;
            address = mk(1, 50); writedata = 8'hEE; read = 1'b1; write = 1'b1;
            e.exp = mdl_rd(mk(1, 50)); e.tag = "R9";
            sbq.push_back(e);
            @(negedge clk); read = 1'b0; write = 1'b0;
            repeat (4) @(negedge clk);
            bus_read(mk(1, 50), "R9");
        end

        // R4 write held behind an outstanding read
        begin
            exp_t e;
            int cnt;
            address = mk(0, 60); read = 1'b1;
            e.exp = mdl_rd(mk(0, 60)); e.tag = "R4";
            sbq.push_back(e);
            @(negedge clk); read = 1'b0;
            address = mk(0, 61); writedata = 8'h3C; write = 1'b1;
            cnt = 0;
            while (waitrequest) begin cnt++; @(negedge clk); end
            chk(cnt == 3, "R4", "busy cycles behind read", cnt, 3);
            mdl[0][61] = 8'h3C;
            @(negedge clk); write = 1'b0;
            @(negedge clk);
            bus_read(mk(0, 61), "R4");
        end

        // R10 reset discards writes
        bus_write(mk(2, 7), 8'hF0);
        bus_read(mk(2, 7), "R2");
        do_reset();
        bus_read(mk(2, 7), "R10");
        bus_read(mk(1, 16), "R10");
        bus_read(mk(0, 255), "R10");

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R3", "responses outstanding", sbq.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule